// File: doc/BRIEF.md
# Implicit ASI and Byte-Order Select Unit

This unit sits beside the load/store and fetch paths of a processor core. For each memory access it works out which address-space identifier (ASI) goes with the request and whether the access is little-endian. It also applies the matching byte reordering to the 64-bit data: store data on the way out, or load data on the way back. Fetches and ordinary data accesses take an implicit ASI that depends on the trap level and on the current-little-endian control bit. Alternate-space accesses and prefetch-alternate accesses name their ASI explicitly, either through the instruction's immediate field or through the ASI register. For those two kinds the unit checks privilege before the request is allowed to proceed.

A little-endian doubleword transfer is handled as two independent 32-bit words. Each word has its bytes reversed in place, and the two words keep their positions. A single 64-bit little-endian item has its eight bytes reversed end to end. The results appear one clock after a valid request. They carry a valid flag and stay stable until the next request arrives.

Top module: `asi_endian_unit`

## Requirements
- R1: A fetch (accessType=0) yields ASI PrimaryAsi (default 0x80) when trapLevel is 0 and NucleusAsi (default 0x04) otherwise. It always reports littleOut=0 and passes dataIn through unchanged.
- R2: A normal data access (accessType=1) at trapLevel 0 yields PrimaryAsi when curLittle=0 and PrimaryLittleAsi (default 0x88) when curLittle=1. In both cases littleOut equals curLittle.
- R3: A normal data access at a trapLevel above 0 yields NucleusAsi when curLittle=0 and NucleusLittleAsi (default 0x0C) when curLittle=1. In both cases littleOut equals curLittle.
- R4: An alternate-space access (accessType=2) or prefetch-alternate access (accessType=3) takes its ASI from immAsi when immBit=0 and from asiReg when immBit=1. Its littleOut is bit 3 (LittleAsiBit) of the chosen ASI.
- R5: When littleOut=1 and isDword=1, each 32-bit word of dataIn has its four bytes reversed, and the two words stay in their own halves.
- R6: When littleOut=1 and isDword=0, all eight bytes of dataIn are reversed. When littleOut=0, dataOut equals dataIn.
- R7: A nonprivileged (privMode=0) alternate-space access whose ASI is below 0x80 (RestrictLimit) sets privExc. A privileged access, or an ASI of 0x80 or above, sets neither privExc nor noOp.
- R8: A nonprivileged prefetch-alternate access whose ASI is below 0x80 sets noOp when PrefetchTraps=0 (the default) and sets privExc when PrefetchTraps=1. privExc and noOp are never high together.
- R9: Every output is registered. outValid is high in the cycle after each cycle in which inValid was high and low otherwise. When inValid is low, asiOut, littleOut, dataOut, privExc and noOp keep their previous values.
- R10: After reset, outValid, asiOut, littleOut, dataOut, privExc and noOp are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| accessType | input | 2 | 0 fetch, 1 normal data, 2 alternate-space data, 3 prefetch-alternate |
| trapLevel | input | TlW (3) | Current trap level |
| curLittle | input | 1 | Current-little-endian control bit |
| privMode | input | 1 | Privileged mode |
| immBit | input | 1 | Instruction i bit (1 selects the ASI register) |
| immAsi | input | AsiW (8) | Instruction immediate ASI field |
| asiReg | input | AsiW (8) | ASI register value |
| isDword | input | 1 | 1: transfer is two 32-bit words; 0: one 64-bit item |
| dataIn | input | DataW (64) | Store data or returned load data |
| outValid | output | 1 | Results valid |
| asiOut | output | AsiW (8) | Selected ASI |
| littleOut | output | 1 | Access is little-endian |
| dataOut | output | DataW (64) | Byte-reordered data |
| privExc | output | 1 | Privileged-action exception |
| noOp | output | 1 | Prefetch suppressed as a no-op |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid pipeline and the holding of the outputs between requests;
- that fetches are big-endian and pass data through unchanged;
- that privileged requests never raise privExc or noOp, and that the two flags never rise together;
- that a little-endian-off data access at trap level 0 selects the primary ASI.

Only the directed scenarios show the exact ASI value for each combination of trap level and endian bit, and the choice between the immediate field and the ASI register. The same holds for the two byte-swap patterns, checked against known constants, and for the privilege and no-op outcomes at the 0x7F/0x80 boundary.

// File: rtl/asi_endian_pkg.sv
package asi_endian_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_ALT   = 2'd2,
    ACC_PFALT = 2'd3
  } accessKind_e;

  typedef struct packed {
    logic loadEn;    // capture new data this cycle
    logic swapEn;    // apply a byte reorder
    logic wordMode;  // reorder within each 32-bit word
  } ctrlStrobe_t;

endpackage

// File: rtl/asi_endian_ctrl.sv
module asi_endian_ctrl
  import asi_endian_pkg::*;
#(
  parameter int AsiW             = 8,
  parameter int TlW              = 3,
  parameter int PrimaryAsi       = 'h80,
  parameter int PrimaryLittleAsi = 'h88,
  parameter int NucleusAsi       = 'h04,
  parameter int NucleusLittleAsi = 'h0C,
  parameter int RestrictLimit    = 'h80,
  parameter int LittleAsiBit     = 3,
  parameter bit PrefetchTraps    = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [1:0]      accessType,
  input  logic [TlW-1:0]  trapLevel,
  input  logic            curLittle,
  input  logic            privMode,
  input  logic            immBit,
  input  logic [AsiW-1:0] immAsi,
  input  logic [AsiW-1:0] asiReg,
  input  logic            isDword,
  output ctrlStrobe_t     strobe,
  output logic            outValid,
  output logic [AsiW-1:0] asiOut,
  output logic            littleOut,
  output logic            privExc,
  output logic            noOp
);

  localparam logic [AsiW-1:0] PrimCode    = AsiW'(PrimaryAsi);
  localparam logic [AsiW-1:0] PrimLitCode = AsiW'(PrimaryLittleAsi);
  localparam logic [AsiW-1:0] NucCode     = AsiW'(NucleusAsi);
  localparam logic [AsiW-1:0] NucLitCode  = AsiW'(NucleusLittleAsi);
  localparam logic [AsiW-1:0] LimitCode   = AsiW'(RestrictLimit);

  accessKind_e     kind;
  logic [AsiW-1:0] explicitAsi;
  logic            atTopLevel;
  logic            restricted;
  logic [AsiW-1:0] nextAsi;
  logic            nextLittle;
  logic            nextExc;
  logic            nextNoOp;

  assign kind        = accessKind_e'(accessType);
  assign explicitAsi = immBit ? asiReg : immAsi;
  assign atTopLevel  = (trapLevel == '0);
  assign restricted  = (explicitAsi < LimitCode) && !privMode;

  always_comb begin
    nextAsi    = PrimCode;
    nextLittle = 1'b0;
    nextExc    = 1'b0;
    nextNoOp   = 1'b0;
    unique case (kind)
      ACC_FETCH: begin
        nextAsi    = atTopLevel ? PrimCode : NucCode;
        nextLittle = 1'b0;
      end
      ACC_DATA: begin
        if (atTopLevel) nextAsi = curLittle ? PrimLitCode : PrimCode;
        else            nextAsi = curLittle ? NucLitCode  : NucCode;
        nextLittle = curLittle;
      end
      ACC_ALT: begin
        nextAsi    = explicitAsi;
        nextLittle = explicitAsi[LittleAsiBit];
        nextExc    = restricted;
      end
      ACC_PFALT: begin
        nextAsi    = explicitAsi;
        nextLittle = explicitAsi[LittleAsiBit];
        if (PrefetchTraps) nextExc  = restricted;
        else               nextNoOp = restricted;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobe.loadEn   = inValid;
    strobe.swapEn   = nextLittle;
    strobe.wordMode = isDword;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      asiOut    <= '0;
      littleOut <= 1'b0;
      privExc   <= 1'b0;
      noOp      <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        asiOut    <= nextAsi;
        littleOut <= nextLittle;
        privExc   <= nextExc;
        noOp      <= nextNoOp;
      end
    end
  end

endmodule

// File: rtl/asi_endian_dpath.sv
module asi_endian_dpath
  import asi_endian_pkg::*;
#(
  parameter int DataW = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [DataW-1:0] dataIn,
  output logic [DataW-1:0] dataOut
);

  localparam int ByteCnt   = DataW / 8;
  localparam int WordBytes = 4;
  localparam int WordCnt   = ByteCnt / WordBytes;

  logic [DataW-1:0] fullRev;
  logic [DataW-1:0] wordRev;
  logic [DataW-1:0] nextData;

  // Reverse the bytes of the whole item, end to end
  for (genvar b = 0; b < ByteCnt; b++) begin : g_full
    assign fullRev[b*8 +: 8] = dataIn[(ByteCnt-1-b)*8 +: 8];
  end

  // Reverse the bytes inside each 32-bit word; words stay in place
  for (genvar w = 0; w < WordCnt; w++) begin : g_word
    for (genvar k = 0; k < WordBytes; k++) begin : g_lane
      assign wordRev[(w*WordBytes+k)*8 +: 8] =
             dataIn[(w*WordBytes+WordBytes-1-k)*8 +: 8];
    end
  end

  always_comb begin
    if (!strobe.swapEn)       nextData = dataIn;
    else if (strobe.wordMode) nextData = wordRev;
    else                      nextData = fullRev;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              dataOut <= '0;
    else if (strobe.loadEn) dataOut <= nextData;
  end

endmodule

// File: rtl/asi_endian_unit.sv
module asi_endian_unit
  import asi_endian_pkg::*;
#(
  parameter int AsiW             = 8,
  parameter int TlW              = 3,
  parameter int DataW            = 64,
  parameter int PrimaryAsi       = 'h80,
  parameter int PrimaryLittleAsi = 'h88,
  parameter int NucleusAsi       = 'h04,
  parameter int NucleusLittleAsi = 'h0C,
  parameter int RestrictLimit    = 'h80,
  parameter int LittleAsiBit     = 3,
  parameter bit PrefetchTraps    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       accessType,
  input  logic [TlW-1:0]   trapLevel,
  input  logic             curLittle,
  input  logic             privMode,
  input  logic             immBit,
  input  logic [AsiW-1:0]  immAsi,
  input  logic [AsiW-1:0]  asiReg,
  input  logic             isDword,
  input  logic [DataW-1:0] dataIn,
  output logic             outValid,
  output logic [AsiW-1:0]  asiOut,
  output logic             littleOut,
  output logic [DataW-1:0] dataOut,
  output logic             privExc,
  output logic             noOp
);

  ctrlStrobe_t strobe;

  asi_endian_ctrl #(
    .AsiW(AsiW), .TlW(TlW),
    .PrimaryAsi(PrimaryAsi), .PrimaryLittleAsi(PrimaryLittleAsi),
    .NucleusAsi(NucleusAsi), .NucleusLittleAsi(NucleusLittleAsi),
    .RestrictLimit(RestrictLimit), .LittleAsiBit(LittleAsiBit),
    .PrefetchTraps(PrefetchTraps)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accessType(accessType),
    .trapLevel(trapLevel), .curLittle(curLittle), .privMode(privMode),
    .immBit(immBit), .immAsi(immAsi), .asiReg(asiReg), .isDword(isDword),
    .strobe(strobe), .outValid(outValid), .asiOut(asiOut),
    .littleOut(littleOut), .privExc(privExc), .noOp(noOp)
  );

  asi_endian_dpath #(.DataW(DataW)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/asi_endian_checker.sv
module asi_endian_checker #(
  parameter int AsiW       = 8,
  parameter int TlW        = 3,
  parameter int DataW      = 64,
  parameter int PrimaryAsi = 'h80
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       accessType,
  input logic [TlW-1:0]   trapLevel,
  input logic             curLittle,
  input logic             privMode,
  input logic [DataW-1:0] dataIn,
  input logic             outValid,
  input logic [AsiW-1:0]  asiOut,
  input logic             littleOut,
  input logic [DataW-1:0] dataOut,
  input logic             privExc,
  input logic             noOp
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(asiOut) && $stable(dataOut) && $stable(littleOut)
                  && $stable(privExc) && $stable(noOp)));

  assert_fetch_big_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && accessType == 2'd0) |=> (!littleOut && dataOut == $past(dataIn)));

  assert_primary_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && accessType == 2'd1 && trapLevel == '0 && !curLittle)
      |=> (asiOut == AsiW'(PrimaryAsi)));

  assert_priv_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && privMode) |=> (!privExc && !noOp));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(privExc && noOp));

endmodule

bind asi_endian_unit asi_endian_checker #(
  .AsiW(AsiW), .TlW(TlW), .DataW(DataW), .PrimaryAsi(PrimaryAsi)
) i_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .accessType(accessType),
  .trapLevel(trapLevel), .curLittle(curLittle), .privMode(privMode),
  .dataIn(dataIn), .outValid(outValid), .asiOut(asiOut),
  .littleOut(littleOut), .dataOut(dataOut), .privExc(privExc), .noOp(noOp)
);

// File: tb/test_asi_endian_unit.sv
`timescale 1ns/1ps
module test_asi_endian_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  accessType = 2'd0;
  logic [2:0]  trapLevel = 3'd0;
  logic        curLittle = 1'b0;
  logic        privMode = 1'b0;
  logic        immBit = 1'b0;
  logic [7:0]  immAsi = 8'h00;
  logic [7:0]  asiReg = 8'h00;
  logic        isDword = 1'b0;
  logic [63:0] dataIn = '0;
  logic        outValid;
  logic [7:0]  asiOut;
  logic        littleOut;
  logic [63:0] dataOut;
  logic        privExc;
  logic        noOp;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [63:0] Pattern  = 64'h0011_2233_4455_6677;
  localparam logic [63:0] WordSwap = 64'h3322_1100_7766_5544;
  localparam logic [63:0] FullSwap = 64'h7766_5544_3322_1100;

  always #2.5 clk = ~clk;

  asi_endian_unit i_asi_endian_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accessType(accessType),
    .trapLevel(trapLevel), .curLittle(curLittle), .privMode(privMode),
    .immBit(immBit), .immAsi(immAsi), .asiReg(asiReg), .isDword(isDword),
    .dataIn(dataIn), .outValid(outValid), .asiOut(asiOut),
    .littleOut(littleOut), .dataOut(dataOut), .privExc(privExc), .noOp(noOp)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // Drive one request at a falling edge; results sampled 1 ns after the
  // capturing rising edge.
  task automatic doAccess(input logic [1:0] typ, input logic [2:0] tl,
                          input logic cl, input logic pv, input logic ib,
                          input logic [7:0] ia, input logic [7:0] ar,
                          input logic dw, input logic [63:0] d);
    @(negedge clk);
    inValid = 1'b1; accessType = typ; trapLevel = tl; curLittle = cl;
    privMode = pv; immBit = ib; immAsi = ia; asiReg = ar; isDword = dw;
    dataIn = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    inValid = 1'b0;
    dataIn = ~d;
  endtask

  task automatic testReset();
    chkEq("R10 outValid", {63'd0, outValid}, 64'd0);
    chkEq("R10 asiOut", {56'd0, asiOut}, 64'd0);
    chkEq("R10 littleOut", {63'd0, littleOut}, 64'd0);
    chkEq("R10 dataOut", dataOut, 64'd0);
    chkEq("R10 flags", {62'd0, privExc, noOp}, 64'd0);
  endtask

  task automatic testFetch();
    doAccess(2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, Pattern);
    chkEq("R1 fetch tl0 asi", {56'd0, asiOut}, 64'h80);
    chkEq("R1 fetch big-endian", {63'd0, littleOut}, 64'd0);
    chkEq("R1 fetch data", dataOut, Pattern);
    doAccess(2'd0, 3'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, Pattern);
    chkEq("R1 fetch tl>0 asi", {56'd0, asiOut}, 64'h04);
  endtask

  task automatic testDataTl0();
    doAccess(2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, Pattern);
    chkEq("R2 primary", {56'd0, asiOut}, 64'h80);
    chkEq("R6 big passthrough", dataOut, Pattern);
    doAccess(2'd1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, Pattern);
    chkEq("R2 primary-little", {56'd0, asiOut}, 64'h88);
    chkEq("R2 little flag", {63'd0, littleOut}, 64'd1);
    chkEq("R5 word swap", dataOut, WordSwap);
  endtask

  task automatic testDataTlHigh();
    doAccess(2'd1, 3'd1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, Pattern);
    chkEq("R3 nucleus", {56'd0, asiOut}, 64'h04);
    doAccess(2'd1, 3'd7, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, Pattern);
    chkEq("R3 nucleus-little", {56'd0, asiOut}, 64'h0C);
    chkEq("R6 full swap", dataOut, FullSwap);
  endtask

  task automatic testAlternate();
    doAccess(2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 8'h15, 8'h88, 1'b1, Pattern);
    chkEq("R4 immediate asi", {56'd0, asiOut}, 64'h15);
    chkEq("R4 imm big", {63'd0, littleOut}, 64'd0);
    doAccess(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, 8'h15, 8'h88, 1'b1, Pattern);
    chkEq("R4 register asi", {56'd0, asiOut}, 64'h88);
    chkEq("R4 reg little", {63'd0, littleOut}, 64'd1);
    chkEq("R5 alt word swap", dataOut, WordSwap);
  endtask

  task automatic testPrivilege();
    doAccess(2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0, Pattern);
    chkEq("R7 restricted exc", {62'd0, privExc, noOp}, 64'd2);
    doAccess(2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, Pattern);
    chkEq("R7 unrestricted", {62'd0, privExc, noOp}, 64'd0);
    doAccess(2'd2, 3'd0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0, Pattern);
    chkEq("R7 privileged", {62'd0, privExc, noOp}, 64'd0);
  endtask

  task automatic testPrefetch();
    doAccess(2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h40, 1'b0, Pattern);
    chkEq("R8 prefetch noop", {62'd0, privExc, noOp}, 64'd1);
    doAccess(2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81, 1'b0, Pattern);
    chkEq("R8 prefetch allowed", {62'd0, privExc, noOp}, 64'd0);
  endtask

  task automatic testHold();
    doAccess(2'd1, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, Pattern);
    chkEq("R9 valid after request", {63'd0, outValid}, 64'd1);
    @(posedge clk);
    #1;
    chkEq("R9 valid drops", {63'd0, outValid}, 64'd0);
    chkEq("R9 asi held", {56'd0, asiOut}, 64'h88);
    chkEq("R9 data held", dataOut, FullSwap);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testFetch();
    testDataTl0();
    testDataTlHigh();
    testAlternate();
    testPrivilege();
    testPrefetch();
    testHold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule